// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when a four-bank SDR SDRAM is owed an auto-refresh. The rows have to be refreshed on a budget of 8192 refreshes per 64 ms, which is one refresh about every 7.8 µs. An interval timer is derived from the clock period and raises one refresh obligation each time it wraps. Obligations collect in a saturating backlog, so the command controller can put them off during long accesses and then issue them back to back.

The scheduler asserts a request while the backlog is non-zero. The controller grants once it has closed every bank. A grant counts only when all banks are reported precharged and the row cycle time of the previous refresh has run out. Each accepted grant removes one obligation and starts a row-cycle hold. When the backlog is full, an urgent flag tells the controller to refresh before it starts any new access.

While the memory is in self-refresh, the scheduler makes no requests. The interval timer is frozen and the backlog is emptied.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, `refresh_req_o`, `urgent_o` and `busy_o` are low and `backlog_o` is 0.
- R2: One refresh obligation is added every INTERVAL clock cycles, where INTERVAL = floor(REFI_PS / CLK_PERIOD_PS) - MARGIN_CYC. The first obligation appears on the INTERVAL-th rising edge after reset release.
- R3: `refresh_req_o` is high exactly when `backlog_o` is non-zero and `self_ref_i` is low.
- R4: A grant is accepted when `grant_i`, `refresh_req_o` and `all_idle_i` are high and `busy_o` is low. An accepted grant lowers `backlog_o` by one on that edge.
- R5: A grant while `all_idle_i` is low (a bank is open) is ignored, and the backlog is unchanged.
- R6: After an accepted grant, `busy_o` stays high for TRC_CYC = ceil(TRC_PS / CLK_PERIOD_PS) cycles. Grants during that time are ignored.
- R7: The backlog saturates at BACKLOG_MAX. Further obligations are dropped and the count does not wrap.
- R8: `urgent_o` is high exactly when `backlog_o` equals BACKLOG_MAX.
- R9: If an obligation is added and a grant is accepted on the same edge, `backlog_o` does not change.
- R10: While `self_ref_i` is high, the backlog is cleared and the interval timer holds its count. After exit, the timer resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| self_ref_i | input | 1 | Memory is in self-refresh |
| all_idle_i | input | 1 | All four banks are precharged |
| grant_i | input | 1 | Controller issues the refresh this cycle |
| refresh_req_o | output | 1 | Refresh wanted |
| urgent_o | output | 1 | Backlog full; serve before any access |
| busy_o | output | 1 | Row cycle time of the last refresh still running |
| backlog_o | output | BW | Number of pending refreshes |

## Verification
Some rules are checked on every cycle by assertions:
- The request, urgent flag and backlog always agree with each other.
- Self-refresh empties the backlog and silences the request.
- An accepted grant removes exactly one obligation and starts the busy hold.
- A grant while a bank is open leaves the count unchanged.
- No grant is accepted during the busy hold.

Other behaviour can only be shown by the bench scenarios, because it depends on absolute cycle counts:
- the exact edge on which each obligation appears;
- the full length of the busy window;
- saturation after many intervals;
- the merged tick-and-grant edge;
- the timer resuming from its frozen count after self-refresh.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Cycles between refresh obligations, rounded down, less a safety margin.
  function automatic int interval_cycles(int refi_ps, int period_ps, int margin);
    return (refi_ps / period_ps) - margin;
  endfunction

  // A time converted to whole clock cycles, rounded up.
  function automatic int ceil_cycles(int t_ps, int period_ps);
    return (t_ps + period_ps - 1) / period_ps;
  endfunction

  // Counter width needed to hold values 0..n.
  function automatic int width_for(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
  parameter int INTERVAL = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = rf_pkg::width_for(INTERVAL - 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!hold) begin
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end

  assign tick = !hold && (cnt == LAST);
endmodule

// File: rtl/rf_backlog.sv
module rf_backlog #(
  parameter int MAX = 8,
  parameter int BW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic          dec,
  output logic [BW-1:0] level
);
  localparam logic [BW-1:0] FULL = BW'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      level <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (level != FULL) level <= level + BW'(1);
        2'b01:   if (level != '0)   level <= level - BW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rf_trc_timer.sv
module rf_trc_timer #(
  parameter int TRC_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int TW = rf_pkg::width_for(TRC_CYC);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= TW'(TRC_CYC);
    end else if (remain != '0) begin
      remain <= remain - TW'(1);
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CLK_PERIOD_PS = 7500,
  parameter int REFI_PS       = 7812500,
  parameter int MARGIN_CYC    = 1,
  parameter int TRC_PS        = 65000,
  parameter int BACKLOG_MAX   = 8,
  parameter int BW            = rf_pkg::width_for(BACKLOG_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          self_ref_i,
  input  logic          all_idle_i,
  input  logic          grant_i,
  output logic          refresh_req_o,
  output logic          urgent_o,
  output logic          busy_o,
  output logic [BW-1:0] backlog_o
);
  localparam int INTERVAL = rf_pkg::interval_cycles(REFI_PS, CLK_PERIOD_PS, MARGIN_CYC);
  localparam int TRC_CYC  = rf_pkg::ceil_cycles(TRC_PS, CLK_PERIOD_PS);

  // Internal events, brought out as named wires for the checker.
  logic tick_w;
  logic accept_w;

  rf_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (self_ref_i),
    .tick (tick_w)
  );

  assign refresh_req_o = (backlog_o != '0) && !self_ref_i;
  assign accept_w      = grant_i && refresh_req_o && all_idle_i && !busy_o;
  assign urgent_o      = (backlog_o == BW'(BACKLOG_MAX));

  rf_backlog #(.MAX(BACKLOG_MAX), .BW(BW)) u_backlog (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(self_ref_i),
    .inc  (tick_w),
    .dec  (accept_w),
    .level(backlog_o)
  );

  rf_trc_timer #(.TRC_CYC(TRC_CYC)) u_trc (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept_w),
    .busy (busy_o)
  );
endmodule

// File: rtl/rf_sched_checker.sv
module rf_sched_checker #(
  parameter int MAX = 8,
  parameter int BW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          self_ref_i,
  input logic          all_idle_i,
  input logic          grant_i,
  input logic          refresh_req_o,
  input logic          urgent_o,
  input logic          busy_o,
  input logic [BW-1:0] backlog_o,
  input logic          tick_w,
  input logic          accept_w
);
  AST_REQ_NEEDS_BACKLOG: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_o |-> (backlog_o != '0) && !self_ref_i); // R3
  AST_BACKLOG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    backlog_o <= BW'(MAX)); // R7
  AST_URGENT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> backlog_o == BW'(MAX)); // R8
  AST_SELFREF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref_i |=> backlog_o == '0); // R10
  AST_SELFREF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    self_ref_i |-> !refresh_req_o); // R10
  AST_GRANT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !tick_w && !self_ref_i) |=> backlog_o == $past(backlog_o) - BW'(1)); // R4
  AST_OPEN_BANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && !all_idle_i && !tick_w && !self_ref_i) |=> backlog_o == $past(backlog_o)); // R5
  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o); // R6
  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_w); // R6
endmodule

bind sdram_refresh_sched rf_sched_checker #(.MAX(BACKLOG_MAX), .BW(BW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .self_ref_i   (self_ref_i),
  .all_idle_i   (all_idle_i),
  .grant_i      (grant_i),
  .refresh_req_o(refresh_req_o),
  .urgent_o     (urgent_o),
  .busy_o       (busy_o),
  .backlog_o    (backlog_o),
  .tick_w       (tick_w),
  .accept_w     (accept_w)
);

// File: tb/tb_sdram_refresh_sched.sv
`timescale 1ns/1ps
module tb_sdram_refresh_sched;
  localparam int PER_PS = 8000;
  localparam int REFI   = 160000;
  localparam int MARG   = 1;
  localparam int TRC    = 65000;
  localparam int BMAX   = 8;
  localparam int BW     = 4;
  // Restated from the requirements: 160000/8000 - 1 and ceil(65000/8000).
  localparam int IV  = REFI / PER_PS - MARG;   // 19
  localparam int TRCC = (TRC + PER_PS - 1) / PER_PS; // 9

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic self_ref = 1'b0, all_idle = 1'b0, grant = 1'b0;
  logic req, urgent, busy;
  logic [BW-1:0] backlog;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_refresh_sched #(
    .CLK_PERIOD_PS(PER_PS), .REFI_PS(REFI), .MARGIN_CYC(MARG),
    .TRC_PS(TRC), .BACKLOG_MAX(BMAX), .BW(BW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .self_ref_i(self_ref), .all_idle_i(all_idle),
    .grant_i(grant), .refresh_req_o(req), .urgent_o(urgent), .busy_o(busy),
    .backlog_o(backlog)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; self_ref = 1'b0; all_idle = 1'b0; grant = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic grant_once();
    all_idle = 1'b1; grant = 1'b1;
    step(1);
    grant = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 req", req, 0);
    chk("R1 urgent", urgent, 0);
    chk("R1 busy", busy, 0);
    chk("R1 backlog", backlog, 0);
  endtask

  task automatic t_interval();
    do_reset();
    step(IV - 1);
    chk("R2 before tick", backlog, 0);
    chk("R3 no req", req, 0);
    step(1);
    chk("R2 first tick", backlog, 1);
    chk("R3 req", req, 1);
    step(IV);
    chk("R2 second tick", backlog, 2);
  endtask

  task automatic t_grant_busy();
    do_reset();
    step(IV);
    grant_once();
    chk("R4 decrement", backlog, 0);
    chk("R6 busy start", busy, 1);
    chk("R3 req drops", req, 0);
    step(TRCC - 1);
    chk("R6 busy end-1", busy, 1);
    step(1);
    chk("R6 busy cleared", busy, 0);
  endtask

  task automatic t_open_bank();
    do_reset();
    step(IV);
    all_idle = 1'b0; grant = 1'b1;
    step(1);
    grant = 1'b0;
    chk("R5 open bank ignored", backlog, 1);
    chk("R5 no busy", busy, 0);
  endtask

  task automatic t_grant_while_busy();
    do_reset();
    step(2 * IV);
    chk("R2 two owed", backlog, 2);
    all_idle = 1'b1; grant = 1'b1;
    step(1);
    chk("R4 first grant", backlog, 1);
    step(1);
    grant = 1'b0;
    chk("R6 grant in busy ignored", backlog, 1);
    chk("R3 req held", req, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    step(BMAX * IV - 1);
    chk("R8 not yet urgent", urgent, 0);
    step(1);
    chk("R7 full", backlog, BMAX);
    chk("R8 urgent", urgent, 1);
    step(IV);
    chk("R7 no wrap", backlog, BMAX);
    grant_once();
    chk("R4 from full", backlog, BMAX - 1);
    chk("R8 urgent drops", urgent, 0);
  endtask

  task automatic t_merge();
    do_reset();
    step(2 * IV - 1);
    chk("R2 one owed", backlog, 1);
    grant_once();
    chk("R9 merged edge", backlog, 1);
    chk("R6 merged busy", busy, 1);
  endtask

  task automatic t_self_ref();
    do_reset();
    step(IV + 5);
    chk("R2 owed", backlog, 1);
    self_ref = 1'b1;
    #1;
    chk("R10 req quiet", req, 0);
    step(1);
    chk("R10 cleared", backlog, 0);
    all_idle = 1'b1;
    step(3 * IV);
    chk("R10 no ticks", backlog, 0);
    self_ref = 1'b0;
    step(IV - 6);
    chk("R10 held count", backlog, 0);
    step(1);
    chk("R10 resume tick", backlog, 1);
  endtask

  initial begin
    t_reset();
    t_interval();
    t_grant_busy();
    t_open_bank();
    t_grant_while_busy();
    t_saturate();
    t_merge();
    t_self_ref();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule